// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 64K words, each 4 bits wide. The host hands over one access at a time through a valid/ready request channel: a 16-bit word address, a write flag and 4 bits of write data. The block turns each request into a strobe sequence for the memory. It drives the address, two active-low chip selects that always move together, an active-low write strobe and an active-low output enable. Its own data driver has separate out, in and drive-enable signals.

All minimum timings are parameters in nanoseconds, together with the clock period. Each one is rounded up to a whole number of cycles. A write is controlled by the write strobe, and output enable stays high for the whole write. The write strobe rises while data is still being driven, and the data is then held for at least one more cycle. A write always ends with one idle cycle with the driver off, so a read that follows cannot turn the memory's outputs on into a driven bus. Read data is sampled one cycle after the access time has passed, stored in a register, and returned with a single-cycle valid pulse.

Back-pressure rules: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. The host must keep the address, flag and data steady until then. `req_ready` is high only while no access is in flight. The response channel has no ready: `rsp_valid` is a single-cycle pulse and the host must take it.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While idle and after reset, both chip selects, the write strobe and output enable are high, the data driver is off, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays low until the access is complete, and a request held high during that time is not taken twice.
- R3: For a write, the selects go low for one cycle with the write strobe high. The write strobe then stays low for max(ceil(tPWE/T), ceil(tSD/T)) cycles, which is 1 at the defaults. Output enable is high throughout, and the write strobe is low only while the memory is selected.
- R4: The driver is on, carrying the request's write data, for every cycle the write strobe is low and for at least one cycle after it rises. The memory then holds the written value.
- R5: `sram_addr` shows the accepted address from the cycle after acceptance to the end of the access, and never changes while the write strobe is low.
- R6: For a read, the selects and output enable are low and the write strobe is high for ACC+1 cycles, where ACC = max(ceil(tAA/T), ceil(tDOE/T)) = 2 at the defaults. The bus is sampled at the end of that window. `rsp_valid` is high for exactly one cycle, ACC+2 cycles after the accepting edge, with the sampled word on `rsp_rdata`.
- R7: Every write ends with one cycle in which all strobes are high, the driver is off and `req_ready` is low. Output enable never falls in a cycle that directly follows a cycle with the driver on, so the block and the memory never drive the bus together.
- R8: The two chip selects are equal in every cycle.
- R9: For a write, the selects stay low with the address held for at least ceil(tWC/T) cycles.
- R10: `rsp_rdata` keeps the last read word until the next read completes. Later writes and bus activity do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 4 | Registered read data |
| sram_addr | output | 16 | Memory address bus |
| sram_ce1_n | output | 1 | First chip select, active low |
| sram_ce2_n | output | 1 | Second chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 4 | Data the block drives onto the bus |
| sram_dq_in | input | 4 | Data seen on the bus |
| sram_dq_oe | output | 1 | Block's data driver enable |

## Verification
Two things can fall in the same cycle: the response pulse of one read, and the acceptance of the next request. `req_ready` comes back in the very cycle `rsp_valid` is high. The bench holds `req_valid` high with a second address through the whole first read, so the second read is taken on the edge that ends the response cycle. It checks three things: the first word arrives intact, the new address shows with output enable low one cycle later, and the second word then arrives from the new location. A cycle-level memory model returns inverted data until the access time has passed on a stable address. It also counts bus contention and any write-pulse or hold shortfall, so an early sample or an overlapping driver shows up as a wrong word or a non-zero count.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_TURNAROUND
  } ctrl_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic int cyc_of(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
  import sram_ctrl_pkg::*;
(
  input  ctrl_state_e state,
  output strobe_t     strobes
);
  always_comb begin
    strobes = STROBE_QUIET;
    case (state)
      ST_RD_ACCESS, ST_RD_CAPTURE: begin
        strobes.ce_n = 1'b0;
        strobes.oe_n = 1'b0;
      end
      ST_WR_SETUP: strobes.ce_n = 1'b0;
      ST_WR_PULSE: begin
        strobes.ce_n = 1'b0;
        strobes.we_n = 1'b0;
        strobes.drv  = 1'b1;
      end
      ST_WR_HOLD: begin
        strobes.ce_n = 1'b0;
        strobes.drv  = 1'b1;
      end
      default: strobes = STROBE_QUIET;
    endcase
  end
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) rdata <= bus_in;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_WC_NS       = 12,
  parameter int T_PWE_NS      = 8,
  parameter int T_SD_NS       = 8,
  parameter int T_AA_NS       = 12,
  parameter int T_DOE_NS      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);
  // Cycle counts derived from nanosecond minima, rounded up
  localparam int PWE_CYC  = imax(cyc_of(T_PWE_NS, CLK_PERIOD_NS), cyc_of(T_SD_NS, CLK_PERIOD_NS));
  localparam int ACC_CYC  = imax(cyc_of(T_AA_NS, CLK_PERIOD_NS), cyc_of(T_DOE_NS, CLK_PERIOD_NS));
  localparam int WC_CYC   = cyc_of(T_WC_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC = imax(1, WC_CYC - 1 - PWE_CYC);
  localparam int MAX_CYC  = imax(PWE_CYC, imax(ACC_CYC, HOLD_CYC));
  localparam int CNT_W    = imax(1, $clog2(MAX_CYC));

  ctrl_state_e       state_q, state_d;
  strobe_t           strobe_next, strobe_q;
  logic              accept;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d  = ST_RD_ACCESS;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      ST_RD_ACCESS:  if (tmr_done) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_IDLE;
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PWE_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          state_d  = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WR_HOLD:    if (tmr_done) state_d = ST_TURNAROUND;
      ST_TURNAROUND: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_strobe_decode u_decode (
    .state   (state_d),
    .strobes (strobe_next)
  );

  // Strobes registered from the next state: glitch-free pins aligned with state_q
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      strobe_q <= STROBE_QUIET;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_next;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  sram_read_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (state_q == ST_RD_CAPTURE),
    .bus_in  (sram_dq_in),
    .rdata   (rsp_rdata),
    .valid   (rsp_valid)
  );

  assign sram_addr   = addr_q;
  assign sram_ce1_n  = strobe_q.ce_n;
  assign sram_ce2_n  = strobe_q.ce_n;
  assign sram_we_n   = strobe_q.we_n;
  assign sram_oe_n   = strobe_q.oe_n;
  assign sram_dq_oe  = strobe_q.drv;
  assign sram_dq_out = wdata_q;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W  = 16,
  parameter int PWE_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce1_n,
  input logic              sram_ce2_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);
  logic [7:0] we_run;

  always_ff @(posedge clk) begin
    if (!rst_n)           we_run <= '0;
    else if (sram_we_n)   we_run <= '0;
    else if (we_run != 8'hFF) we_run <= we_run + 8'd1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_we_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce1_n && sram_oe_n));

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (int'(we_run) >= PWE_CYC));

  p_hold_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);

  p_drive_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_ce1_n));

  p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));

  p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_oe_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> !$past(sram_dq_oe));

  p_ce_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce1_n == sram_ce2_n);
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .PWE_CYC (PWE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce1_n (sram_ce1_n),
  .sram_ce2_n (sram_ce2_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int E_PWE = (8 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_ACC = (12 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_WC  = (12 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [15:0] sram_addr;
  logic        ce1_n, ce2_n, we_n, oe_n, dq_oe;
  logic [3:0]  dq_out, dq_in;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl #(.CLK_PERIOD_NS(CLK_PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce1_n(ce1_n), .sram_ce2_n(ce2_n),
    .sram_we_n(we_n), .sram_oe_n(oe_n),
    .sram_dq_out(dq_out), .sram_dq_in(dq_in), .sram_dq_oe(dq_oe)
  );

  // Cycle-level memory model, evaluated mid-cycle
  logic [3:0]  mem [256];
  int          we_run = 0, rd_run = 0, contention = 0, tviol = 0;
  logic        prev_we_n = 1'b1;
  logic [15:0] prev_addr = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = i[3:0] ^ 4'h5;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce1_n && !oe_n && dq_oe) contention++;
      if (!we_n) begin
        if (ce1_n || ce2_n || !dq_oe) tviol++;
        if (we_run > 0 && sram_addr != prev_addr) tviol++;
        we_run++;
      end else if (!prev_we_n) begin
        if (we_run < E_PWE || !dq_oe) tviol++;
        mem[sram_addr[7:0]] = dq_out;
        we_run = 0;
      end
      if (!ce1_n && !ce2_n && !oe_n && we_n)
        rd_run = (sram_addr == prev_addr) ? rd_run + 1 : 1;
      else
        rd_run = 0;
      prev_we_n = we_n;
      prev_addr = sram_addr;
    end
  end

  assign dq_in = (rd_run >= E_ACC) ? mem[sram_addr[7:0]] : ~mem[sram_addr[7:0]];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ce1_n && ce2_n && we_n && oe_n && !dq_oe, "R1 strobes in reset", {ce1_n, we_n, oe_n, dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 ready after reset", {req_ready, rsp_valid}, 2'b10);
    chk(ce1_n && we_n && oe_n && !dq_oe, "R1 idle strobes", {ce1_n, we_n, oe_n, dq_oe}, 4'b1110);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [3:0] d);
    int ce_cycles = 0;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2 busy after accept", req_ready, 0);
    chk(!ce1_n && we_n && oe_n && !dq_oe, "R3 setup cycle", {ce1_n, we_n, oe_n, dq_oe}, 4'b0110);
    chk(sram_addr == a, "R5 address", sram_addr, a);
    ce_cycles += int'(!ce1_n);
    @(negedge clk);
    chk(!we_n && oe_n, "R3 write strobe low, oe high", {we_n, oe_n}, 2'b01);
    chk(dq_oe && dq_out == d, "R4 data driven", {dq_oe, dq_out}, {1'b1, d});
    ce_cycles += int'(!ce1_n);
    @(negedge clk);
    chk(we_n && dq_oe && dq_out == d && !ce1_n, "R4 hold after release", {we_n, dq_oe, dq_out}, {2'b11, d});
    chk(sram_addr == a, "R5 address held", sram_addr, a);
    ce_cycles += int'(!ce1_n);
    @(negedge clk);
    chk(ce1_n && we_n && oe_n && !dq_oe && !req_ready, "R7 turnaround idle", {ce1_n, we_n, oe_n, dq_oe, req_ready}, 5'b11100);
    @(negedge clk);
    chk(req_ready, "R1 ready after write", req_ready, 1);
    chk(ce_cycles >= E_WC, "R9 write cycle length", ce_cycles, E_WC);
    chk(mem[a[7:0]] == d, "R4 memory stored", mem[a[7:0]], d);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [3:0] e);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2 busy after accept", req_ready, 0);
    chk(!ce1_n && !oe_n && we_n && sram_addr == a, "R6 read strobes", {ce1_n, oe_n, we_n}, 3'b001);
    chk(ce1_n == ce2_n, "R8 selects equal", {ce1_n, ce2_n}, {ce1_n, ce1_n});
    @(negedge clk);
    chk(!ce2_n && !oe_n && we_n && !rsp_valid, "R6 access cycle 2", {ce2_n, oe_n, rsp_valid}, 3'b000);
    @(negedge clk);
    chk(!oe_n && !rsp_valid, "R6 capture cycle", {oe_n, rsp_valid}, 2'b00);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == e, "R6 read data", {rsp_valid, rsp_rdata}, {1'b1, e});
    chk(req_ready && oe_n, "R1 idle after read", {req_ready, oe_n}, 2'b11);
    @(negedge clk);
    chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
  endtask

  // Response pulse of read A coincides with acceptance of read B
  task automatic t_back_to_back(input logic [15:0] a, input logic [3:0] ea,
                                input logic [15:0] b, input logic [3:0] eb);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_addr = b;
    @(negedge clk);
    @(negedge clk);
    chk(!req_ready && sram_addr == a, "R2 held request not retaken", {req_ready, sram_addr}, {1'b0, a});
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == ea, "R6 first word", {rsp_valid, rsp_rdata}, {1'b1, ea});
    chk(req_ready, "R2 ready in response cycle", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready && !oe_n && sram_addr == b, "R5 second address", sram_addr, b);
    chk(!rsp_valid, "R6 pulse ends", rsp_valid, 0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == eb, "R6 second word", {rsp_valid, rsp_rdata}, {1'b1, eb});
    @(negedge clk);
  endtask

  task automatic t_rdata_keeps(input logic [15:0] a, input logic [3:0] old_v, input logic [3:0] new_v);
    do_read(a, old_v);
    do_write(a, new_v);
    chk(rsp_rdata == old_v, "R10 read data kept", rsp_rdata, old_v);
    do_read(a, new_v);
    chk(rsp_rdata == new_v, "R10 updated by next read", rsp_rdata, new_v);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=complete");
    finish_run();
  end

  initial begin
    t_reset();
    do_write(16'hA512, 4'h9);
    do_read(16'hA512, 4'h9);
    do_read(16'h1234, 4'h1);
    do_write(16'h3C07, 4'h6);
    do_write(16'h80FF, 4'h0);
    do_read(16'h3C07, 4'h6);
    do_read(16'h80FF, 4'h0);
    t_back_to_back(16'hA512, 4'h9, 16'h3C07, 4'h6);
    t_rdata_keeps(16'h4E21, 4'h4, 4'hB);
    chk(contention == 0, "R7 no bus contention", contention, 0);
    chk(tviol == 0, "R3 write timing in model", tviol, 0);
    finish_run();
  end
endmodule